// File: doc/BRIEF.md
# Mailbox Deadline Scanner

This block watches a set of message mailboxes for missed delivery deadlines. Each mailbox owns a deadline value, kept in a single-port synchronous RAM, and a time-out enable bit. A small controller walks the RAM one entry per clock, in ascending mailbox order, wrapping from the last mailbox back to the first. When an entry's read data arrives, it is compared against the current time-stamp value. If the deadline has passed, the enable is set and the mailbox is still waiting, the mailbox's bit in a per-mailbox status vector is set.

A transmit mailbox counts as waiting while its transmit request is raised. A receive mailbox counts as waiting while its receive-pending bit is clear. Because the check is sequential, a mailbox that completes before the sweep reaches it is never flagged. Status bits clear by themselves when the owning mailbox later reports success, or when its enable is dropped. Software can also clear them by writing ones. A summary flag shows whether any status bit is set. A one-cycle interrupt pulse marks each rising edge of that flag.

Deadline values are loaded through the same RAM port that the scan uses. A load takes the port for its cycle, and the scan pauses for that cycle.

Top module: `mbox_deadline_scan`

## Requirements
- R1: For a transmit mailbox (direction bit 1), its status bit becomes 1 only when all three of these hold at its scan visit: time stamp >= deadline (equality counts), enable = 1, and transmit request = 1. If any of them is false, the bit stays 0.
- R2: For a receive mailbox (direction bit 0), its status bit becomes 1 only when, at its scan visit, time stamp >= deadline, enable = 1 and receive-pending = 0.
- R3: The scan pointer starts at mailbox 0 after reset and advances by one per cycle in which no deadline load takes place. It wraps from the last mailbox to mailbox 0, so every mailbox, the first and the last included, is visited. The comparison uses the RAM data one cycle after the address was presented.
- R4: A one-cycle success pulse on a mailbox's done input clears that mailbox's status bit on the next clock edge.
- R5: While a mailbox's enable bit is 0, its status bit is 0 from the next clock edge on.
- R6: After reset the status vector, the summary flag and the interrupt are all 0.
- R7: The summary flag is 1 exactly when at least one status bit is 1, and it returns to 0 once all bits are clear.
- R8: The interrupt is a one-cycle pulse raised in the cycle the summary flag goes from 0 to 1. It does not pulse again while the flag stays 1, and clearing the flag later does not retract it.
- R9: A software clear with mask bit n = 1 clears status bit n on the next edge. If the scan sets bit n at that same edge, the set wins.
- R10: A deadline load writes the given value into the addressed mailbox's RAM entry, and later scans compare against that value. While a load is in progress the scan pointer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tstamp_i | input | TS_W | Free-running time-stamp value |
| dl_wr_en_i | input | 1 | Deadline load strobe |
| dl_wr_idx_i | input | IDX_W | Mailbox addressed by the load |
| dl_wr_data_i | input | TS_W | Deadline value to store |
| toen_i | input | N | Per-mailbox time-out enable |
| txreq_i | input | N | Per-mailbox transmit request |
| rxpend_i | input | N | Per-mailbox receive pending |
| is_tx_i | input | N | Per-mailbox direction, 1 = transmit |
| done_i | input | N | Per-mailbox success pulse |
| cpu_clr_en_i | input | 1 | Software clear strobe |
| cpu_clr_mask_i | input | N | Write-one-to-clear mask |
| status_o | output | N | Per-mailbox time-out status |
| tflag_o | output | 1 | Summary time-out flag |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench targets the cases where a missing condition would wrongly set a bit. These are a request already dropped, a message already received, an enable held low, and a time stamp one below the deadline against one exactly equal to it. A design that used strict greater-than, or ignored the direction bit, would then show a flag where none belongs. It checks that mailboxes 0 and the last one are both flagged, which catches a pointer that wraps early or late. It also checks that a freshly loaded deadline replaces the old one. Finally, it holds a software clear across a whole sweep and counts exactly one cycle with the bit set. A design that let the clear win would show zero such cycles, and a second pulse on an already-raised flag would show up as an extra interrupt.

// File: rtl/mds_pkg.sv
package mds_pkg;

  // Scan controller state: what the RAM port did in the previous cycle
  typedef enum logic [1:0] {
    SC_START = 2'd0,  // nothing read yet after reset
    SC_FETCH = 2'd1,  // a scan read was issued, data valid now
    SC_YIELD = 2'd2   // port was taken by a deadline load
  } scan_st_e;

endpackage

// File: rtl/mds_rst_sync.sv
module mds_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/mds_deadline_ram.sv
module mds_deadline_ram #(
  parameter int DEPTH = 32,
  parameter int W     = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[addr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/mds_scan_ctrl.sv
module mds_scan_ctrl
  import mds_pkg::*;
#(
  parameter int N     = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  output logic [IDX_W-1:0] ram_addr,
  output logic             ram_re,
  output logic             rd_valid,
  output logic [IDX_W-1:0] rd_idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  scan_st_e         st_q, st_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] rd_idx_q, rd_idx_d;
  logic             adv;

  assign adv = !ld_en;

  always_comb begin
    st_d     = adv ? SC_FETCH : SC_YIELD;
    ptr_d    = ptr_q;
    rd_idx_d = rd_idx_q;
    if (adv) begin
      ptr_d    = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      rd_idx_d = ptr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SC_START;
      ptr_q    <= '0;
      rd_idx_q <= '0;
    end else begin
      st_q <= st_d;
      if (adv) begin
        ptr_q    <= ptr_d;
        rd_idx_q <= rd_idx_d;
      end
    end
  end

  assign ram_addr = ld_en ? ld_idx : ptr_q;
  assign ram_re   = adv;
  assign rd_valid = (st_q == SC_FETCH);
  assign rd_idx   = rd_idx_q;

  // R3: last mailbox is followed by mailbox 0
  assert_ptr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr_q == LAST) |=> (ptr_q == '0));

  // R3: the visited index is the pointer of the previous fetch cycle
  assert_rd_idx_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (rd_valid && rd_idx == $past(ptr_q)));

  // R10: a load freezes the scan pointer
  assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> $stable(ptr_q));

endmodule

// File: rtl/mds_status_reg.sv
module mds_status_reg #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] done_i,
  input  logic [N-1:0] toen_i,
  input  logic         cpu_clr_en,
  input  logic [N-1:0] cpu_clr_mask,
  output logic [N-1:0] status_o,
  output logic         flag_o,
  output logic         irq_o
);

  logic [N-1:0] status_q, status_d, clr_vec;
  logic         flag_q, flag_d;
  logic         irq_q, irq_d;
  logic         status_en;

  always_comb begin
    clr_vec   = done_i | ~toen_i | (cpu_clr_en ? cpu_clr_mask : '0);
    status_d  = (status_q & ~clr_vec) | set_vec;
    status_en = (status_d != status_q);
    flag_d    = |status_d;
    irq_d     = flag_d & ~flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (status_en) status_q <= status_d;
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign status_o = status_q;
  assign flag_o   = flag_q;
  assign irq_o    = irq_q;

  // R9: a hardware set always lands, whatever clears arrive
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // R4: success pulse removes the bit
  assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_i & ~set_vec) != '0) |=> ((status_q & $past(done_i & ~set_vec)) == '0));

  // R5: disabled mailboxes hold no status
  assert_disable_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (~toen_i != '0) |=> ((status_q & ~$past(toen_i)) == '0));

  // R7: summary flag agrees with the status vector
  assert_flag_any_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q == (status_q != '0));

  // R8: interrupt only in the cycle the flag rises
  assert_irq_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (flag_q && !$past(flag_q)));

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

endmodule

// File: rtl/mbox_deadline_scan.sv
module mbox_deadline_scan #(
  parameter int N      = 32,
  parameter int TS_W   = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  tstamp_i,
  input  logic             dl_wr_en_i,
  input  logic [IDX_W-1:0] dl_wr_idx_i,
  input  logic [TS_W-1:0]  dl_wr_data_i,
  input  logic [N-1:0]     toen_i,
  input  logic [N-1:0]     txreq_i,
  input  logic [N-1:0]     rxpend_i,
  input  logic [N-1:0]     is_tx_i,
  input  logic [N-1:0]     done_i,
  input  logic             cpu_clr_en_i,
  input  logic [N-1:0]     cpu_clr_mask_i,
  output logic [N-1:0]     status_o,
  output logic             tflag_o,
  output logic             irq_o
);

  logic             rst_n_s;
  logic [IDX_W-1:0] ram_addr;
  logic             ram_re;
  logic [TS_W-1:0]  ram_rdata;
  logic             rd_valid;
  logic [IDX_W-1:0] rd_idx;
  logic             late, waiting, hit;
  logic [N-1:0]     set_vec;

  mds_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  mds_scan_ctrl #(.N(N)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ld_en    (dl_wr_en_i),
    .ld_idx   (dl_wr_idx_i),
    .ram_addr (ram_addr),
    .ram_re   (ram_re),
    .rd_valid (rd_valid),
    .rd_idx   (rd_idx)
  );

  mds_deadline_ram #(.DEPTH(N), .W(TS_W)) u_ram (
    .clk   (clk),
    .we    (dl_wr_en_i),
    .re    (ram_re),
    .addr  (ram_addr),
    .wdata (dl_wr_data_i),
    .rdata (ram_rdata)
  );

  // Deadline check for the mailbox whose entry arrived this cycle
  always_comb begin
    late    = (tstamp_i >= ram_rdata);
    waiting = is_tx_i[rd_idx] ? txreq_i[rd_idx] : ~rxpend_i[rd_idx];
    hit     = rd_valid && late && toen_i[rd_idx] && waiting;
  end

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign set_vec[g] = hit && (rd_idx == IDX_W'(g));
  end

  mds_status_reg #(.N(N)) u_stat (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .set_vec      (set_vec),
    .done_i       (done_i),
    .toen_i       (toen_i),
    .cpu_clr_en   (cpu_clr_en_i),
    .cpu_clr_mask (cpu_clr_mask_i),
    .status_o     (status_o),
    .flag_o       (tflag_o),
    .irq_o        (irq_o)
  );

  // R1/R2: at most one mailbox is flagged per scan step
  assert_one_set_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(set_vec));

  // R1: a transmit mailbox without request never gets a new bit
  assert_tx_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_valid && is_tx_i[rd_idx] && !txreq_i[rd_idx] && !status_o[rd_idx])
      |=> !status_o[$past(rd_idx)]);

  // R2: a receive mailbox whose message arrived never gets a new bit
  assert_rx_pending_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_valid && !is_tx_i[rd_idx] && rxpend_i[rd_idx] && !status_o[rd_idx])
      |=> !status_o[$past(rd_idx)]);

endmodule

// File: tb/mbox_deadline_scan_tb.sv
module mbox_deadline_scan_tb;

  localparam int N    = 32;
  localparam int TS_W = 16;
  localparam int IW   = 5;

  logic            clk;
  logic            rst_n;
  logic [TS_W-1:0] tstamp;
  logic            dl_we;
  logic [IW-1:0]   dl_idx;
  logic [TS_W-1:0] dl_data;
  logic [N-1:0]    toen, txreq, rxpend, is_tx, done, clr_mask;
  logic            clr_en;
  logic [N-1:0]    status;
  logic            tflag, irq;

  mbox_deadline_scan #(.N(N), .TS_W(TS_W)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .tstamp_i       (tstamp),
    .dl_wr_en_i     (dl_we),
    .dl_wr_idx_i    (dl_idx),
    .dl_wr_data_i   (dl_data),
    .toen_i         (toen),
    .txreq_i        (txreq),
    .rxpend_i       (rxpend),
    .is_tx_i        (is_tx),
    .done_i         (done),
    .cpu_clr_en_i   (clr_en),
    .cpu_clr_mask_i (clr_mask),
    .status_o       (status),
    .tflag_o        (tflag),
    .irq_o          (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    logic [N-1:0] st;
    logic         fl;
    int           irqs;
    string        tag;
  } exp_t;

  exp_t         sb_q[$];
  int           checks = 0;
  int           errors = 0;
  int           irq_cnt = 0;
  int           exp_irq = 0;
  logic [N-1:0] exp_st = '0;
  bit           finished = 0;

  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(status == e.st, {e.tag, " status"}, $sformatf("%h", status), $sformatf("%h", e.st));
        check(tflag == e.fl, {e.tag, " flag"}, $sformatf("%0d", tflag), $sformatf("%0d", e.fl));
        check(irq_cnt == e.irqs, {e.tag, " irq count"}, $sformatf("%0d", irq_cnt), $sformatf("%0d", e.irqs));
      end
    end
  end

  // Driver side: push the model's expectation at the current negedge
  task automatic expect_now(input string tag);
    exp_t e;
    e.st = exp_st; e.fl = (exp_st != '0); e.irqs = exp_irq; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_deadline(input int idx, input int val);
    @(negedge clk);
    dl_we = 1'b1; dl_idx = IW'(idx); dl_data = TS_W'(val);
    @(negedge clk);
    dl_we = 1'b0;
  endtask

  task automatic finish_run();
    cycles(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tstamp = '0; dl_we = 1'b0; dl_idx = '0; dl_data = '0;
    toen = '0; txreq = '0; rxpend = '0; is_tx = '0; done = '0;
    clr_en = 1'b0; clr_mask = '0;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    expect_now("R6 reset state");

    // Load deadlines: all 100, mailbox 6 gets 300
    for (int i = 0; i < N; i++) load_deadline(i, (i == 6) ? 300 : 100);
    tstamp = 16'd200; txreq = '1; is_tx = '1;
    cycles(40);
    expect_now("R1 enable low, nothing flagged");

    // R1: all conditions met on mailbox 3
    toen[3] = 1'b1;
    cycles(40);
    exp_st[3] = 1'b1; exp_irq++;
    expect_now("R1 tx timeout sets bit, R7 flag, R8 irq");

    // R1: request already dropped
    toen[5] = 1'b1; txreq[5] = 1'b0;
    cycles(40);
    expect_now("R1 dropped request not flagged");

    // R1 boundary and R10 load: mailbox 6 deadline 300
    toen[6] = 1'b1;
    cycles(40);
    expect_now("R10 loaded deadline 300 not yet reached");
    tstamp = 16'd299;
    cycles(40);
    expect_now("R1 one below deadline");
    tstamp = 16'd300;
    cycles(40);
    exp_st[6] = 1'b1;
    expect_now("R1 equal to deadline flags, R8 no second irq");

    // R2: receive mailbox 8
    is_tx[8] = 1'b0; rxpend[8] = 1'b1; toen[8] = 1'b1;
    cycles(40);
    expect_now("R2 receive pending not flagged");
    rxpend[8] = 1'b0;
    cycles(40);
    exp_st[8] = 1'b1;
    expect_now("R2 receive missing flagged");

    // R3: first and last mailbox across the wrap
    toen[0] = 1'b1; toen[31] = 1'b1;
    cycles(40);
    exp_st[0] = 1'b1; exp_st[31] = 1'b1;
    expect_now("R3 mailboxes 0 and 31 visited");

    // R4: success pulse on mailbox 3
    @(negedge clk);
    txreq[3] = 1'b0; done[3] = 1'b1;
    @(negedge clk);
    done[3] = 1'b0;
    exp_st[3] = 1'b0;
    expect_now("R4 done pulse clears bit");
    cycles(40);
    expect_now("R4 bit stays clear");

    // R5: drop enable of mailbox 8
    @(negedge clk);
    toen[8] = 1'b0;
    @(negedge clk);
    exp_st[8] = 1'b0;
    expect_now("R5 enable low clears bit");

    // R9: clear held over a full sweep while mailbox 0 still times out
    begin
      int hi = 0;
      @(negedge clk);
      clr_en = 1'b1; clr_mask = '0; clr_mask[0] = 1'b1;
      for (int i = 0; i < N; i++) begin
        @(negedge clk);
        #2;
        if (status[0]) hi++;
      end
      check(hi == 1, "R9 set wins over clear", $sformatf("%0d", hi), "1");
      clr_en = 1'b0; clr_mask = '0;
    end
    @(negedge clk);
    toen[0] = 1'b0;
    @(negedge clk);
    exp_st[0] = 1'b0;
    expect_now("R5 mailbox 0 cleared by enable");

    // R9: plain write-one-to-clear on mailbox 31
    @(negedge clk);
    txreq[31] = 1'b0; clr_en = 1'b1; clr_mask = '0; clr_mask[31] = 1'b1;
    @(negedge clk);
    clr_en = 1'b0; clr_mask = '0;
    exp_st[31] = 1'b0;
    expect_now("R9 software clear");
    cycles(40);
    expect_now("R9 stays clear");

    // R7: last bit cleared drops the flag
    tstamp = 16'd0;
    @(negedge clk);
    clr_en = 1'b1; clr_mask = '0; clr_mask[6] = 1'b1;
    @(negedge clk);
    clr_en = 1'b0; clr_mask = '0;
    exp_st[6] = 1'b0;
    expect_now("R7 flag drops, R8 irq not retracted");

    // R10: reload mailbox 12 deadline and verify it takes effect
    tstamp = 16'd200;
    load_deadline(12, 500);
    toen[12] = 1'b1; txreq[12] = 1'b1; is_tx[12] = 1'b1;
    cycles(40);
    expect_now("R10 new deadline 500 not reached");
    load_deadline(12, 150);
    cycles(40);
    exp_st[12] = 1'b1; exp_irq++;
    expect_now("R10 new deadline 150 reached, R8 new irq");

    cycles(3);
    if (!finished) begin
      finished = 1;
      finish_run();
    end
  end

endmodule